// File: doc/BRIEF.md
# Sampled-Entropy Random Word Collector

This block is the digital front end of a hardware random number source. A single raw entropy bit arrives on an input port from a free-running oscillator circuit outside the block. Once a collection is launched, the block captures that bit once every N core clock cycles and packs the captured bits into a result buffer of 64, 128, 192 or 256 bits.

Software drives the block through a single-cycle register port. It programs the capture period, the result length and a 2-bit oscillator speed code. It then sets the enable bit, writes the start bit, and polls the control register until the start bit reads back as zero. After that it reads the result words from an eight-word data window.

A write to a separate reset register abandons any running collection and wipes the buffer.

Top module: `rng_collector`

## Requirements
- R1: After reset the control register reads 0, the period register reads 1000, every data word reads 0, and `osc_speed` and `osc_enable` are low.
- R2: Control bits [5:4] select the result length: code 0 is 64 bits, 1 is 128, 2 is 192 and 3 is 256. A collection of L bits at effective period N keeps the start bit set for exactly L*N cycles after the accepting write edge.
- R3: A control write with bit 0 clear stores the enable bit (bit 1), the speed code (bits [3:2]) and the length code (bits [5:4]). Enable is driven on `osc_enable` and the speed code on `osc_speed`, and the control register reads all three back in place.
- R4: A control write with bit 0 set is a start command and leaves the other fields untouched. Control bit 0 reads 1 while a collection runs and clears itself when the last bit is captured.
- R5: Bit k of a collection (k from 0) is the `entropy_in` value present just before clock edge (k+1)*N after the start edge, where N is the value of the period register at offset 0x404.
- R6: A period value of 0 behaves as a period of 1.
- R7: Captured bits fill the data window at offset 0x410 least significant bit first, beginning with word 0. Words past the selected length read 0.
- R8: A start command is ignored if enable is low, or if a collection is already running. The running collection keeps its timing and its data.
- R9: A control write with bit 0 and bit 1 both clear stops a running collection at once. Writing 0 clears every field and both oscillator ports.
- R10: Any write to offset 0x004 ends a running collection and clears the whole buffer. The stored configuration is kept.
- R11: Results stay unchanged after a collection finishes until the next accepted start. An accepted start clears the buffer in the same edge.
- R12: Reads of unmapped or unaligned offets return 0, and this includes offset 0x004.
- R13: The period register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Write when high, read when low |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle |
| entropy_in | input | 1 | Raw entropy bit from the oscillator |
| osc_speed | output | 2 | Speed code to the oscillator |
| osc_enable | output | 1 | Oscillator enable |

## Verification
The entropy input is driven from a hash of the absolute cycle number. Every cycle therefore carries a distinct bit, and a capture one cycle early or late, or a bit placed out of order, changes the packed words.

Collections run at every length code and at periods 0, 1, 3 and 5. These runs separate the length decode, the zero-period clamp and the period counting, both through the busy duration and through the data.

Further runs add a restart issued mid-run, a start issued with enable low, a stop write and a reset-register write. These runs tell ignored commands apart from accepted ones and show that stored results survive until the next start.

// File: rtl/rngc_pkg.sv
package rngc_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int BUF_BITS  = WORD_W * NUM_WORDS;
  localparam int IDX_W     = $clog2(BUF_BITS);

  localparam int OFS_CLR   = 'h004;
  localparam int OFS_CTL   = 'h400;
  localparam int OFS_PER   = 'h404;
  localparam int OFS_DATA  = 'h410;

  typedef enum logic [1:0] {
    LEN_64  = 2'd0,
    LEN_128 = 2'd1,
    LEN_192 = 2'd2,
    LEN_256 = 2'd3
  } len_sel_e;

  typedef struct packed {
    len_sel_e   len;
    logic [1:0] speed;
    logic       en;
  } ctl_cfg_t;

  // number of bits gathered for a length code: (code+1)*64
  function automatic logic [IDX_W:0] len_to_bits(len_sel_e c);
    return (IDX_W+1)'(({7'd0, c} + 9'd1) << 6);
  endfunction

  // effective capture period: zero is clamped to one
  function automatic logic [31:0] eff_period(logic [31:0] n);
    return (n == 32'd0) ? 32'd1 : n;
  endfunction

endpackage

// File: rtl/rngc_regs.sv
module rngc_regs
  import rngc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 32,
  parameter int DEF_CNT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  output ctl_cfg_t          cfg,
  output logic [CNT_W-1:0]  period,
  output logic              start_evt,
  output logic              abort_evt,
  output logic              clr_evt
);

  logic wr_any;
  logic ctl_wr;
  logic per_wr;
  logic cfg_wr;

  assign wr_any    = reg_sel && reg_wr && (reg_addr[1:0] == 2'b00);
  assign ctl_wr    = wr_any && (reg_addr == ADDR_W'(OFS_CTL));
  assign per_wr    = wr_any && (reg_addr == ADDR_W'(OFS_PER));
  assign clr_evt   = wr_any && (reg_addr == ADDR_W'(OFS_CLR));
  assign cfg_wr    = ctl_wr && !reg_wdata[0];
  assign start_evt = ctl_wr && reg_wdata[0] && cfg.en && !busy;
  assign abort_evt = cfg_wr && !reg_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      period <= CNT_W'(DEF_CNT);
    end else begin
      if (cfg_wr) begin
        cfg.en    <= reg_wdata[1];
        cfg.speed <= reg_wdata[3:2];
        cfg.len   <= len_sel_e'(reg_wdata[5:4]);
      end
      if (per_wr) period <= reg_wdata[CNT_W-1:0];
    end
  end

  // R3: a non-start write must be visible in the stored fields next cycle
  a_r3_cfg_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg.en == $past(reg_wdata[1])) && (cfg.speed == $past(reg_wdata[3:2])));

  // R4: a start command never changes configuration
  a_r4_start_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[0]) |=> $stable(cfg));

endmodule

// File: rtl/rngc_pacer.sv
module rngc_pacer
  import rngc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;
  logic [31:0]      eff;
  logic             at_end;

  assign eff    = eff_period(32'(period));
  assign at_end = (32'(cnt) == (eff - 32'd1));
  assign tick   = run && !restart && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (at_end)            cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R5: after every capture the spacing counter starts over
  a_r5_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

  // R6: the counter never passes the effective period, even at period 0
  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(period)) |-> (32'(cnt) < eff));

endmodule

// File: rtl/rngc_packer.sv
module rngc_packer
  import rngc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_evt,
  input  logic                  abort_evt,
  input  logic                  clr_evt,
  input  logic                  tick,
  input  logic                  bit_in,
  input  len_sel_e              len,
  output logic                  busy,
  output logic                  done,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] words
);

  logic [BUF_BITS-1:0] bits;
  logic [IDX_W-1:0]    idx;
  len_sel_e            run_len;
  logic                last_bit;

  assign last_bit = ({1'b0, idx} == (len_to_bits(run_len) - 1'b1));
  assign done     = busy && tick && last_bit;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    assign words[g] = bits[g*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits    <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      run_len <= LEN_64;
    end else if (clr_evt) begin
      bits <= '0;
      idx  <= '0;
      busy <= 1'b0;
    end else if (abort_evt) begin
      busy <= 1'b0;
    end else if (start_evt) begin
      bits    <= '0;
      idx     <= '0;
      busy    <= 1'b1;
      run_len <= len;
    end else if (busy && tick) begin
      bits[idx] <= bit_in;
      idx       <= idx + 1'b1;
      if (last_bit) busy <= 1'b0;
    end
  end

  // R2: the write position stays inside the selected length
  a_r2_idx_in_len: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, idx} < len_to_bits(run_len)));

  // R4: busy only drops on completion, stop or clear
  a_r4_busy_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done || abort_evt || clr_evt));

  // R11: an idle buffer holds its contents
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_evt && !clr_evt) |=> $stable(bits));

  // R10: a clear leaves nothing behind
  a_r10_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (bits == '0) && !busy);

endmodule

// File: rtl/rng_collector.sv
module rng_collector
  import rngc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 32,
  parameter int DEF_CNT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              entropy_in,
  output logic [1:0]        osc_speed,
  output logic              osc_enable
);

  localparam int DATA_SPAN = NUM_WORDS * 4;

  ctl_cfg_t          cfg;
  logic [CNT_W-1:0]  period;
  logic              start_evt;
  logic              abort_evt;
  logic              clr_evt;
  logic              busy;
  logic              done;
  logic              tick;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;
  logic [ADDR_W-1:0] data_off;
  logic              data_hit;
  logic [2:0]        data_idx;

  rngc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEF_CNT(DEF_CNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
    .cfg(cfg), .period(period), .start_evt(start_evt),
    .abort_evt(abort_evt), .clr_evt(clr_evt)
  );

  rngc_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .restart(start_evt || abort_evt || clr_evt),
    .period(period), .tick(tick)
  );

  rngc_packer u_packer (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .abort_evt(abort_evt),
    .clr_evt(clr_evt), .tick(tick), .bit_in(entropy_in), .len(cfg.len),
    .busy(busy), .done(done), .words(words)
  );

  assign osc_speed  = cfg.speed;
  assign osc_enable = cfg.en;

  assign data_off = reg_addr - ADDR_W'(OFS_DATA);
  assign data_hit = (reg_addr >= ADDR_W'(OFS_DATA)) && (data_off < ADDR_W'(DATA_SPAN));
  assign data_idx = data_off[4:2];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[1:0] == 2'b00) begin
      if (reg_addr == ADDR_W'(OFS_CTL))
        reg_rdata = {26'd0, cfg.len, cfg.speed, cfg.en, busy};
      else if (reg_addr == ADDR_W'(OFS_PER))
        reg_rdata = 32'(period);
      else if (data_hit)
        reg_rdata = words[data_idx];
    end
  end

  // R8: a collection only begins while enabled
  a_r8_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg.en));

  // R9: a stop write leaves the block idle
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !busy && !osc_enable);

  // R4: completion always ends the run
  a_r4_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: tb/rng_collector_tb_top.sv
module rng_collector_tb_top;

  localparam int CTL  = 'h400;
  localparam int PER  = 'h404;
  localparam int CLR  = 'h004;
  localparam int DATA = 'h410;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        entropy_in = 1'b0;
  logic [1:0]  osc_speed;
  logic        osc_enable;

  int unsigned cyc = 0;
  int          n_checks = 0;
  int          n_errors = 0;
  logic [31:0] exp_q[$];
  logic [31:0] kept[8];

  always #2 clk = ~clk;

  rng_collector dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .entropy_in(entropy_in), .osc_speed(osc_speed), .osc_enable(osc_enable)
  );

  function automatic logic pat(int unsigned c);
    logic [31:0] h;
    h = c * 32'h9E3779B1;
    return h[17] ^ h[29];
  endfunction

  always @(posedge clk) cyc++;
  always @(negedge clk) entropy_in = pat(cyc);

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 12'(a); reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic peek(input int a, output logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 12'(a);
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  // driver side of the scoreboard: expected words of a run
  task automatic push_expected(input int len_bits, input int n_eff, input int unsigned s);
    logic [31:0] w[8];
    for (int i = 0; i < 8; i++) w[i] = '0;
    for (int m = 1; m <= len_bits; m++)
      w[(m-1)/32][(m-1)%32] = pat(s + m*n_eff - 1);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(w[i]);
      kept[i] = w[i];
    end
  endtask

  // monitor side: pop and compare every data word
  task automatic compare_words(input string req);
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      peek(DATA + 4*i, d);
      if (exp_q.size() == 0) check(1'b0, req, d, 32'hx);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(d === e, req, d, e);
      end
    end
  endtask

  task automatic wait_idle(input int unsigned s, output int unsigned dur);
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      peek(CTL, d);
      if (!d[0]) break;
      @(negedge clk);
    end
    dur = cyc - s;
  endtask

  task automatic run(input logic [31:0] ctl, input int per, input int lbits,
                     input string req);
    int unsigned s, dur;
    int          n_eff;
    n_eff = (per == 0) ? 1 : per;
    bus_write(PER, 32'(per));
    bus_write(CTL, ctl);
    bus_write(CTL, 32'h1);
    s = cyc;
    push_expected(lbits, n_eff, s);
    wait_idle(s, dur);
    check(dur == 32'(lbits*n_eff), req, dur, lbits*n_eff);
    compare_words(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int unsigned s, dur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(CTL, d);  check(d == 0, "R1 ctl", d, 0);
    peek(PER, d);  check(d == 1000, "R1 period", d, 1000);
    peek(DATA, d); check(d == 0, "R1 data", d, 0);
    check({osc_speed, osc_enable} == 3'b0, "R1 osc ports", {osc_speed, osc_enable}, 0);
    // R12 unmapped, unaligned, clear register
    peek('h008, d); check(d == 0, "R12 unmapped", d, 0);
    peek('h402, d); check(d == 0, "R12 unaligned", d, 0);
    peek(CLR, d);   check(d == 0, "R12 clear reg", d, 0);
    // R13 period readback
    bus_write(PER, 32'h1234); peek(PER, d); check(d == 32'h1234, "R13 readback", d, 32'h1234);

    // R3 config fields: len0 speed2 enable
    bus_write(CTL, 32'h0A);
    check(osc_speed == 2'd2, "R3 speed port", 32'(osc_speed), 2);
    check(osc_enable, "R3 enable port", 32'(osc_enable), 1);
    peek(CTL, d); check(d == 32'h0A, "R3 ctl readback", d, 32'h0A);

    // R2 R4 R5 R7: 64 bits, period 3
    run(32'h0A, 3, 64, "R5 len64 per3");
    peek(CTL, d); check(d == 32'h0A, "R4 start self-clears", d, 32'h0A);
    // R2 R7: 256 bits, period 1
    run(32'h36, 1, 256, "R2 len256 per1");
    // R6: period 0, 128 bits
    run(32'h12, 0, 128, "R6 per0 len128");

    // R11 stability after completion
    repeat (50) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      peek(DATA + 4*i, d); check(d == kept[i], "R11 stable", d, kept[i]);
    end

    // R11 clear on start, R8 restart ignored: 192 bits, period 5
    bus_write(PER, 5);
    bus_write(CTL, 32'h22);
    bus_write(CTL, 32'h1);
    s = cyc;
    peek(DATA, d); check(d == 0, "R11 cleared at start", d, 0);
    push_expected(192, 5, s);
    repeat (10) @(negedge clk);
    bus_write(CTL, 32'h1);
    wait_idle(s, dur);
    check(dur == 960, "R8 restart ignored timing", dur, 960);
    compare_words("R8 restart ignored data");

    // R8 start while disabled
    bus_write(CTL, 32'h30);
    bus_write(CTL, 32'h1);
    peek(CTL, d); check(d == 32'h30, "R8 disabled start", d, 32'h30);
    peek(DATA, d); check(d == kept[0], "R8 data kept", d, kept[0]);

    // R9 stop
    bus_write(PER, 4);
    bus_write(CTL, 32'h32);
    bus_write(CTL, 32'h1);
    repeat (20) @(negedge clk);
    bus_write(CTL, 32'h0);
    peek(CTL, d); check(d == 0, "R9 stop ctl", d, 0);
    check({osc_speed, osc_enable} == 3'b0, "R9 osc ports", {osc_speed, osc_enable}, 0);
    repeat (10) @(negedge clk);
    peek(CTL, d); check(d == 0, "R9 stays idle", d, 0);

    // R10 clear register
    bus_write(CTL, 32'h32);
    bus_write(CTL, 32'h1);
    repeat (60) @(negedge clk);
    bus_write(CLR, 32'h0);
    peek(CTL, d); check(d == 32'h32, "R10 busy cleared cfg kept", d, 32'h32);
    for (int i = 0; i < 8; i++) begin
      peek(DATA + 4*i, d); check(d == 0, "R10 buffer cleared", d, 0);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule